// File: doc/BRIEF.md
# Secure Page Accept Validation Unit

This unit decides whether an enclave may accept a change that system software made to one of its protected pages. A request names a descriptor (a 64-byte block holding the requested flags) and a destination page. It also carries the metadata entries of both pages, the descriptor flags word, and the fields of a control page when one is involved. The unit runs a fixed chain of checks, one per clock cycle, and stops at the first check that fails.

There are three kinds of outcome. A hard fault is either a general fault or a page fault, and it writes nothing. A soft failure returns a nonzero status with the zero flag set. A success writes back the destination entry with its pending, modified and permission-restricted bits cleared. Between the lock step and the end of the request, the unit marks the destination page as held through `lock_hold`.

Address translation and memory reads happen outside the unit. The requester holds every request input steady from acceptance until `resp_valid`. The exceptions are the two metadata entries, `lock_busy` and `tracked`, which are read live at the step that uses them.

Top module: `pgacc_unit`

## Requirements
- R1: After reset, `req_ready`=1, `resp_valid`=0 and `lock_hold`=0. A request is accepted on a clock edge with `req_valid`=1 and `req_ready`=1. `req_ready` then stays 0 until the cycle in which the one-cycle `resp_valid` pulse is presented.
- R2: If the descriptor address has any of bits [5:0] set, or `desc_in_range`=0, the result is a general fault (`resp_fault`=1). Otherwise, if `desc_in_pmem`=0, the result is a page fault (`resp_fault`=2).
- R3: Metadata entry layout: bit0 valid, bit1 read, bit2 write, bit3 execute, bit4 pending, bit5 modified, bit6 permission-restricted, bit7 blocked, bits[10:8] type (0 regular, 1 control, 2 trimmed, all others illegal), then the page number (AW-12 bits), then the owner (OWW bits). The descriptor entry gives a page fault unless all of the following hold: valid=1, read=1, pending=0, modified=0, blocked=0, type regular, owner equal to `active_owner`, and page number equal to `desc_addr[AW-1:12]`.
- R4: Flags word layout: bit0 R, bit1 W, bit2 X, bit3 pending, bit4 modified, bit5 permission-restricted, bits[10:8] type. Bits [7:6] and [15:11] are reserved. Any nonzero reserved bit gives a general fault.
- R5: If `dst_addr[11:0]` is nonzero or `dst_in_range`=0, the result is a general fault. Otherwise, if `dst_in_pmem`=0, the result is a page fault.
- R6: A request is legal in only two cases. In the first, the type is regular, permission-restricted or pending is set, and modified is clear. In the second, the type is control or trimmed, permission-restricted and pending are clear, and modified is set. Any other combination gives a general fault.
- R7: The destination entry gives a page fault unless it is valid, not blocked, of type 0, 1 or 2, and owned by `active_owner`.
- R8: If `lock_busy`=1 at the lock step, the result is a general fault. Otherwise `lock_hold` rises and stays high until the response. In the next cycle the destination entry's valid bit and owner are checked again, and a failure gives a page fault.
- R9: The destination entry mismatches the request if its page number differs from `dst_addr[AW-1:12]`, or if any of its pending, modified, read, write, execute or type fields differs from the flags word. A mismatch gives no fault, status 8'h13, `resp_zf`=1 and `resp_arith_clr`=1.
- R10: If there is no mismatch but `tracked`=0, the result is no fault, status 8'h0B, `resp_zf`=1 and `resp_arith_clr`=1.
- R11: For a control-type request only, any of the following gives a general fault: `ctl_rsvd_nz`, `ctl_dbg_optin`, `ctl_cur_ssa` >= `ctl_num_ssa`, `ctl_aex_nz` or `ctl_state_nz`. If `encl_64b`=0, either limit whose low 12 bits are not 12'hFFF also gives a general fault. Trimmed and regular requests skip this step.
- R12: On success the unit returns status 0, `resp_zf`=0 and `resp_arith_clr`=1, and pulses `meta_we` with the destination entry minus its pending, modified and permission-restricted bits. A fault returns status 0, `resp_zf`=0 and `resp_arith_clr`=0.
- R13: Checks run in the order R2, R3, R4, R5, R6, R7, R8, R9, R10, R11, and the first failure decides the response. A faulting request never pulses `meta_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| desc_addr | input | AW | Descriptor address |
| desc_in_range | input | 1 | Descriptor address inside enclave range |
| desc_in_pmem | input | 1 | Descriptor resolves to protected memory |
| dst_addr | input | AW | Destination page address |
| dst_in_range | input | 1 | Destination inside enclave range |
| dst_in_pmem | input | 1 | Destination resolves to protected memory |
| active_owner | input | OWW | Identity of the running enclave |
| desc_meta | input | 11+AW-12+OWW | Metadata entry of descriptor page |
| dst_meta | input | 11+AW-12+OWW | Metadata entry of destination page |
| dflags | input | 16 | Requested flags word from the descriptor |
| ctl_rsvd_nz | input | 1 | Control page reserved fields nonzero |
| ctl_dbg_optin | input | 1 | Control page debug opt-in bit |
| ctl_cur_ssa | input | SW | Control page current save-area index |
| ctl_num_ssa | input | SW | Control page save-area count |
| ctl_aex_nz | input | 1 | Control page async exit pointer nonzero |
| ctl_state_nz | input | 1 | Control page state field nonzero |
| ctl_fs_lim | input | 12 | Low bits of first segment limit |
| ctl_gs_lim | input | 12 | Low bits of second segment limit |
| encl_64b | input | 1 | Enclave runs in 64-bit mode |
| lock_busy | input | 1 | Destination held by another accept-class operation |
| tracked | input | 1 | Departed-thread tracking complete |
| lock_hold | output | 1 | Destination page held by this unit |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 2 | 0 none, 1 general fault, 2 page fault |
| resp_status | output | 8 | Status code |
| resp_zf | output | 1 | Zero flag |
| resp_arith_clr | output | 1 | Carry/parity/adjust/overflow/sign flags to be cleared |
| meta_we | output | 1 | Destination metadata write strobe |
| meta_wdata | output | 11+AW-12+OWW | Updated destination entry |

## Verification
The bench goes after the orderings and near-misses. It makes two checks fail together and expects the earlier one to report. A unit that evaluated checks in parallel, or in another order, would report the wrong fault class. It drops the destination valid bit after the lock is taken. A unit without the recheck would then commit to a dead page instead of page-faulting. It sends a trimmed request with bad control fields and a 32-bit control request with a limit of 12'hFFE: a unit that applied control checks too widely or missed the limit rule would flip the outcome. Soft failures are checked for zero-flag and status values and for the absence of a write. A unit that treated them as faults, or wrote on them, would differ at `resp_arith_clr` or `meta_we`.

// File: rtl/pgacc_pkg.sv
package pgacc_pkg;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_GP = 2'd1, FLT_PF = 2'd2} fault_e;

  localparam logic [2:0] PT_REG  = 3'd0;
  localparam logic [2:0] PT_CTL  = 3'd1;
  localparam logic [2:0] PT_TRIM = 3'd2;

  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_MISMATCH = 8'h13;
  localparam logic [7:0] ST_NOTRK    = 8'h0B;

  // metadata entry bit positions
  localparam int MB_VALID = 0;
  localparam int MB_RD    = 1;
  localparam int MB_WR    = 2;
  localparam int MB_EX    = 3;
  localparam int MB_PEND  = 4;
  localparam int MB_MOD   = 5;
  localparam int MB_PR    = 6;
  localparam int MB_BLK   = 7;
  localparam int MB_TYPE  = 8;
  localparam int MB_PAGE  = 11;

  // flags word bit positions
  localparam int FB_RD   = 0;
  localparam int FB_WR   = 1;
  localparam int FB_EX   = 2;
  localparam int FB_PEND = 3;
  localparam int FB_MOD  = 4;
  localparam int FB_PR   = 5;
  localparam int FB_TYPE = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_DADDR, S_DMETA, S_DRSVD, S_XADDR, S_LEGAL, S_XMETA,
    S_LOCK, S_RECHK, S_MATCH, S_TRACK, S_CTL, S_COMMIT
  } step_e;
endpackage

// File: rtl/pgacc_entry.sv
module pgacc_entry
  import pgacc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OWW = 8,
  localparam int PNW = AW - 12,
  localparam int MW  = 11 + PNW + OWW
) (
  input  logic [MW-1:0]  ent,
  input  logic [PNW-1:0] page,
  input  logic [OWW-1:0] owner,
  output logic           f_valid,
  output logic           f_rd,
  output logic           f_wr,
  output logic           f_ex,
  output logic           f_pend,
  output logic           f_mod,
  output logic           f_pr,
  output logic           f_blk,
  output logic [2:0]     f_type,
  output logic           own_ok,
  output logic           page_ok
);
  assign f_valid = ent[MB_VALID];
  assign f_rd    = ent[MB_RD];
  assign f_wr    = ent[MB_WR];
  assign f_ex    = ent[MB_EX];
  assign f_pend  = ent[MB_PEND];
  assign f_mod   = ent[MB_MOD];
  assign f_pr    = ent[MB_PR];
  assign f_blk   = ent[MB_BLK];
  assign f_type  = ent[MB_TYPE +: 3];
  assign page_ok = (ent[MB_PAGE +: PNW] == page);
  assign own_ok  = (ent[MB_PAGE + PNW +: OWW] == owner);
endmodule

// File: rtl/pgacc_legal.sv
module pgacc_legal
  import pgacc_pkg::*;
(
  input  logic [15:0] fl,
  output logic        legal,
  output logic        want_ctl,
  output logic        rsvd_bad
);
  logic [2:0] rq_type;
  logic       reg_case, ctl_case;

  assign rq_type  = fl[FB_TYPE +: 3];
  assign reg_case = (rq_type == PT_REG) && (fl[FB_PR] || fl[FB_PEND]) && !fl[FB_MOD];
  assign ctl_case = ((rq_type == PT_CTL) || (rq_type == PT_TRIM)) &&
                    !fl[FB_PR] && !fl[FB_PEND] && fl[FB_MOD];
  assign legal    = reg_case || ctl_case;
  assign want_ctl = (rq_type == PT_CTL);
  assign rsvd_bad = (|fl[7:6]) || (|fl[15:11]);
endmodule

// File: rtl/pgacc_ctlchk.sv
module pgacc_ctlchk #(
  parameter int SW = 8
) (
  input  logic          rsvd_nz,
  input  logic          dbg_optin,
  input  logic [SW-1:0] cur_ssa,
  input  logic [SW-1:0] num_ssa,
  input  logic          aex_nz,
  input  logic          state_nz,
  input  logic [11:0]   fs_lim,
  input  logic [11:0]   gs_lim,
  input  logic          is64,
  output logic          bad
);
  logic init_bad, lim_bad;

  assign init_bad = rsvd_nz || dbg_optin || (cur_ssa >= num_ssa) || aex_nz || state_nz;
  assign lim_bad  = !is64 && ((fs_lim != 12'hFFF) || (gs_lim != 12'hFFF));
  assign bad      = init_bad || lim_bad;
endmodule

// File: rtl/pgacc_unit.sv
module pgacc_unit
  import pgacc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OWW = 8,
  parameter int SW  = 8,
  localparam int PNW = AW - 12,
  localparam int MW  = 11 + PNW + OWW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  desc_addr,
  input  logic           desc_in_range,
  input  logic           desc_in_pmem,
  input  logic [AW-1:0]  dst_addr,
  input  logic           dst_in_range,
  input  logic           dst_in_pmem,
  input  logic [OWW-1:0] active_owner,
  input  logic [MW-1:0]  desc_meta,
  input  logic [MW-1:0]  dst_meta,
  input  logic [15:0]    dflags,
  input  logic           ctl_rsvd_nz,
  input  logic           ctl_dbg_optin,
  input  logic [SW-1:0]  ctl_cur_ssa,
  input  logic [SW-1:0]  ctl_num_ssa,
  input  logic           ctl_aex_nz,
  input  logic           ctl_state_nz,
  input  logic [11:0]    ctl_fs_lim,
  input  logic [11:0]    ctl_gs_lim,
  input  logic           encl_64b,
  input  logic           lock_busy,
  input  logic           tracked,
  output logic           lock_hold,
  output logic           resp_valid,
  output logic [1:0]     resp_fault,
  output logic [7:0]     resp_status,
  output logic           resp_zf,
  output logic           resp_arith_clr,
  output logic           meta_we,
  output logic [MW-1:0]  meta_wdata
);
  localparam logic [MW-1:0] CLR_MASK = ~((MW'(1) << MB_PEND) | (MW'(1) << MB_MOD) | (MW'(1) << MB_PR));

  // decoded entries
  logic d_valid, d_rd, d_wr, d_ex, d_pend, d_mod, d_pr, d_blk, d_own, d_page;
  logic x_valid, x_rd, x_wr, x_ex, x_pend, x_mod, x_pr, x_blk, x_own, x_page;
  logic [2:0] d_type, x_type;
  logic legal, want_ctl, rsvd_bad, ctl_bad;

  pgacc_entry #(.AW(AW), .OWW(OWW)) u_dent (
    .ent(desc_meta), .page(desc_addr[AW-1:12]), .owner(active_owner),
    .f_valid(d_valid), .f_rd(d_rd), .f_wr(d_wr), .f_ex(d_ex), .f_pend(d_pend),
    .f_mod(d_mod), .f_pr(d_pr), .f_blk(d_blk), .f_type(d_type),
    .own_ok(d_own), .page_ok(d_page));

  pgacc_entry #(.AW(AW), .OWW(OWW)) u_xent (
    .ent(dst_meta), .page(dst_addr[AW-1:12]), .owner(active_owner),
    .f_valid(x_valid), .f_rd(x_rd), .f_wr(x_wr), .f_ex(x_ex), .f_pend(x_pend),
    .f_mod(x_mod), .f_pr(x_pr), .f_blk(x_blk), .f_type(x_type),
    .own_ok(x_own), .page_ok(x_page));

  pgacc_legal u_legal (.fl(dflags), .legal(legal), .want_ctl(want_ctl), .rsvd_bad(rsvd_bad));

  pgacc_ctlchk #(.SW(SW)) u_ctl (
    .rsvd_nz(ctl_rsvd_nz), .dbg_optin(ctl_dbg_optin), .cur_ssa(ctl_cur_ssa),
    .num_ssa(ctl_num_ssa), .aex_nz(ctl_aex_nz), .state_nz(ctl_state_nz),
    .fs_lim(ctl_fs_lim), .gs_lim(ctl_gs_lim), .is64(encl_64b), .bad(ctl_bad));

  logic unused_bits;
  assign unused_bits = ^{desc_addr[11:6], d_wr, d_ex, d_pr, x_pr};

  // next-state logic: one check per step
  step_e  step_q, step_d;
  logic   fin, commit, lock_set;
  fault_e flt_d;
  logic [7:0] st_d;
  logic   mismatch;

  assign mismatch = !x_page || (x_pend != dflags[FB_PEND]) || (x_mod != dflags[FB_MOD]) ||
                    (x_rd != dflags[FB_RD]) || (x_wr != dflags[FB_WR]) ||
                    (x_ex != dflags[FB_EX]) || (x_type != dflags[FB_TYPE +: 3]);

  always_comb begin
    step_d   = step_q;
    fin      = 1'b0;
    commit   = 1'b0;
    lock_set = 1'b0;
    flt_d    = FLT_NONE;
    st_d     = ST_OK;
    unique case (step_q)
      S_IDLE:  if (req_valid) step_d = S_DADDR;
      S_DADDR: begin
        if ((desc_addr[5:0] != 6'd0) || !desc_in_range) begin fin = 1'b1; flt_d = FLT_GP; end
        else if (!desc_in_pmem) begin fin = 1'b1; flt_d = FLT_PF; end
        else step_d = S_DMETA;
      end
      S_DMETA: begin
        if (!d_valid || !d_rd || d_pend || d_mod || d_blk || (d_type != PT_REG) || !d_own || !d_page) begin
          fin = 1'b1; flt_d = FLT_PF;
        end else step_d = S_DRSVD;
      end
      S_DRSVD: if (rsvd_bad) begin fin = 1'b1; flt_d = FLT_GP; end else step_d = S_XADDR;
      S_XADDR: begin
        if ((dst_addr[11:0] != 12'd0) || !dst_in_range) begin fin = 1'b1; flt_d = FLT_GP; end
        else if (!dst_in_pmem) begin fin = 1'b1; flt_d = FLT_PF; end
        else step_d = S_LEGAL;
      end
      S_LEGAL: if (!legal) begin fin = 1'b1; flt_d = FLT_GP; end else step_d = S_XMETA;
      S_XMETA: begin
        if (!x_valid || x_blk || (x_type > PT_TRIM) || !x_own) begin fin = 1'b1; flt_d = FLT_PF; end
        else step_d = S_LOCK;
      end
      S_LOCK: begin
        if (lock_busy) begin fin = 1'b1; flt_d = FLT_GP; end
        else begin lock_set = 1'b1; step_d = S_RECHK; end
      end
      S_RECHK: if (!x_valid || !x_own) begin fin = 1'b1; flt_d = FLT_PF; end else step_d = S_MATCH;
      S_MATCH: if (mismatch) begin fin = 1'b1; st_d = ST_MISMATCH; end else step_d = S_TRACK;
      S_TRACK: if (!tracked) begin fin = 1'b1; st_d = ST_NOTRK; end else step_d = S_CTL;
      S_CTL:   if (want_ctl && ctl_bad) begin fin = 1'b1; flt_d = FLT_GP; end else step_d = S_COMMIT;
      S_COMMIT: begin fin = 1'b1; commit = 1'b1; end
      default: step_d = S_IDLE;
    endcase
    if (fin) step_d = S_IDLE;
  end

  assign req_ready = (step_q == S_IDLE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= S_IDLE;
      lock_hold  <= 1'b0;
      resp_valid <= 1'b0;
      meta_we    <= 1'b0;
    end else begin
      step_q     <= step_d;
      resp_valid <= fin;
      meta_we    <= commit;
      if (fin) lock_hold <= 1'b0;
      else if (lock_set) lock_hold <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_fault     <= FLT_NONE;
      resp_status    <= ST_OK;
      resp_zf        <= 1'b0;
      resp_arith_clr <= 1'b0;
    end else if (fin) begin
      resp_fault     <= flt_d;
      resp_status    <= st_d;
      resp_zf        <= (flt_d == FLT_NONE) && (st_d != ST_OK);
      resp_arith_clr <= (flt_d == FLT_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meta_wdata <= '0;
    else if (commit) meta_wdata <= dst_meta & CLR_MASK;
  end

  // assertions
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R1
  AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lock_hold); // R8
  AST_LOCK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_hold) |-> !$past(lock_busy)); // R8
  AST_SOFT_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_fault == FLT_NONE)) |-> (resp_arith_clr && (resp_zf == (resp_status != 8'd0)))); // R9
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_fault != FLT_NONE)) |-> !meta_we); // R13
  AST_WRITE_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    meta_we |-> (resp_valid && (resp_status == ST_OK) && !resp_zf)); // R12
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    meta_we |-> (!meta_wdata[MB_PEND] && !meta_wdata[MB_MOD] && !meta_wdata[MB_PR])); // R12
endmodule

// File: tb/sim_pgacc_unit.sv
`timescale 1ns/1ps
module sim_pgacc_unit;
  localparam int AW = 32, OWW = 8, SW = 8, MW = 11 + AW - 12 + OWW;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk, rst_n, req_valid, req_ready;
  logic [AW-1:0] desc_addr, dst_addr;
  logic desc_in_range, desc_in_pmem, dst_in_range, dst_in_pmem;
  logic [OWW-1:0] active_owner;
  logic [MW-1:0] desc_meta, dst_meta, meta_wdata;
  logic [15:0] dflags;
  logic ctl_rsvd_nz, ctl_dbg_optin, ctl_aex_nz, ctl_state_nz, encl_64b, lock_busy, tracked;
  logic [SW-1:0] ctl_cur_ssa, ctl_num_ssa;
  logic [11:0] ctl_fs_lim, ctl_gs_lim;
  logic lock_hold, resp_valid, resp_zf, resp_arith_clr, meta_we;
  logic [1:0] resp_fault;
  logic [7:0] resp_status;

  int n_run = 0, n_fail = 0;

  pgacc_unit #(.AW(AW), .OWW(OWW), .SW(SW)) u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [MW-1:0] mk_meta(logic v, logic r, logic w, logic x, logic pd,
      logic md, logic pr, logic bl, logic [2:0] ty, logic [19:0] pg, logic [7:0] ow);
    return {ow, pg, ty, bl, pr, md, pd, x, w, r, v};
  endfunction

  function automatic logic [15:0] mk_fl(logic r, logic w, logic x, logic pd, logic md,
      logic pr, logic [2:0] ty);
    return {5'd0, ty, 2'b00, pr, md, pd, x, w, r};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_good();
    desc_addr = 32'h0001_0040; desc_in_range = 1; desc_in_pmem = 1;
    dst_addr  = 32'h0002_0000; dst_in_range = 1; dst_in_pmem = 1;
    active_owner = OWN;
    desc_meta = mk_meta(1,1,0,0,0,0,0,0,3'd0,20'h00010,OWN);
    dflags    = mk_fl(1,1,0,1,0,0,3'd0);
    dst_meta  = mk_meta(1,1,1,0,1,0,0,0,3'd0,20'h00020,OWN);
    ctl_rsvd_nz = 0; ctl_dbg_optin = 0; ctl_cur_ssa = 8'd0; ctl_num_ssa = 8'd2;
    ctl_aex_nz = 0; ctl_state_nz = 0; ctl_fs_lim = 12'hFFF; ctl_gs_lim = 12'hFFF;
    encl_64b = 1; lock_busy = 0; tracked = 1;
  endtask

  // issue a request and check the response
  task automatic run(string tag, logic [1:0] e_flt, logic [7:0] e_st, logic e_zf,
      logic e_ac, logic e_we, logic [MW-1:0] e_wd, logic drop_after_lock);
    bit got = 0;
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R1 ready low while busy"}, req_ready, 0);
    for (int i = 0; i < 40 && !got; i++) begin
      if (resp_valid) begin
        got = 1;
        chk({tag, " fault"}, resp_fault, e_flt);
        chk({tag, " status"}, resp_status, e_st);
        chk({tag, " zf"}, resp_zf, e_zf);
        chk({tag, " arith_clr"}, resp_arith_clr, e_ac);
        chk({tag, " R13 write strobe"}, meta_we, e_we);
        if (e_we) chk({tag, " R12 write data"}, meta_wdata, e_wd);
        chk({tag, " R8 lock released"}, lock_hold, 0);
      end else begin
        if (drop_after_lock && lock_hold) dst_meta[0] = 0;
        @(negedge clk);
      end
    end
    if (!got) chk({tag, " response seen"}, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset resp_valid", resp_valid, 0);
    chk("R1 reset lock_hold", lock_hold, 0);
  endtask

  task automatic t_success_reg();
    logic [MW-1:0] w;
    set_good(); w = dst_meta; w[4] = 0;
    run("R12 regular accept", 2'd0, 8'h00, 0, 1, 1, w, 0);
  endtask

  task automatic t_desc_addr();
    set_good(); desc_addr[3] = 1;
    run("R2 desc misaligned", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good(); desc_in_range = 0;
    run("R2 desc out of range", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good(); desc_in_pmem = 0;
    run("R2 desc not protected", 2'd2, 0, 0, 0, 0, '0, 0);
    set_good(); desc_in_pmem = 0; desc_addr[0] = 1;
    run("R13 general before page fault", 2'd1, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_desc_meta();
    set_good(); desc_meta[4] = 1;
    run("R3 desc pending", 2'd2, 0, 0, 0, 0, '0, 0);
    set_good(); desc_meta[38:31] = 8'h11;
    run("R3 desc foreign owner", 2'd2, 0, 0, 0, 0, '0, 0);
    set_good(); desc_addr = 32'h0001_1040;
    run("R3 desc page mismatch", 2'd2, 0, 0, 0, 0, '0, 0);
    set_good(); dflags[12] = 1;
    run("R4 reserved flag bit", 2'd1, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_dst_addr();
    set_good(); dst_addr = 32'h0002_0800;
    run("R5 dst misaligned", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good(); dst_in_pmem = 0;
    run("R5 dst not protected", 2'd2, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_legal();
    set_good(); dflags = mk_fl(1,1,0,0,0,0,3'd0);
    run("R6 regular no pend no pr", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good(); dflags = mk_fl(0,0,0,0,0,0,3'd1);
    run("R6 control without modified", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good(); dflags = mk_fl(0,0,0,0,1,0,3'd5);
    run("R6 illegal type", 2'd1, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_dst_meta();
    set_good(); dst_meta[7] = 1;
    run("R7 dst blocked", 2'd2, 0, 0, 0, 0, '0, 0);
    set_good(); dst_meta[10:8] = 3'd4;
    run("R7 dst bad type", 2'd2, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_lock();
    set_good(); lock_busy = 1;
    run("R8 page held elsewhere", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good();
    run("R8 recheck after lock", 2'd2, 0, 0, 0, 0, '0, 1);
    set_good(); lock_busy = 1; desc_meta[0] = 0;
    run("R13 desc entry before lock", 2'd2, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_soft();
    set_good(); dst_meta[2] = 0;
    run("R9 write mismatch", 2'd0, 8'h13, 1, 1, 0, '0, 0);
    set_good(); dst_addr = 32'h0003_0000;
    run("R9 address mismatch", 2'd0, 8'h13, 1, 1, 0, '0, 0);
    set_good(); tracked = 0;
    run("R10 not tracked", 2'd0, 8'h0B, 1, 1, 0, '0, 0);
    set_good(); tracked = 0; dst_meta[1] = 0;
    run("R13 mismatch before tracking", 2'd0, 8'h13, 1, 1, 0, '0, 0);
  endtask

  task automatic t_control();
    logic [MW-1:0] w;
    set_good(); dflags = mk_fl(1,1,0,0,1,0,3'd1);
    dst_meta = mk_meta(1,1,1,0,0,1,0,0,3'd1,20'h00020,OWN);
    w = dst_meta; w[5] = 0;
    run("R11 control accept", 2'd0, 0, 0, 1, 1, w, 0);
    ctl_cur_ssa = 8'd2;
    run("R11 save index not below count", 2'd1, 0, 0, 0, 0, '0, 0);
    ctl_cur_ssa = 8'd1; encl_64b = 0; ctl_fs_lim = 12'hFFE;
    run("R11 32-bit limit low bits", 2'd1, 0, 0, 0, 0, '0, 0);
    ctl_fs_lim = 12'hFFF;
    run("R11 32-bit limits ok", 2'd0, 0, 0, 1, 1, w, 0);
    ctl_aex_nz = 1;
    run("R11 async exit pointer", 2'd1, 0, 0, 0, 0, '0, 0);
    set_good(); dflags = mk_fl(0,0,0,0,1,0,3'd2);
    dst_meta = mk_meta(1,0,0,0,0,1,0,0,3'd2,20'h00020,OWN);
    ctl_dbg_optin = 1; w = dst_meta; w[5] = 0;
    run("R11 trimmed skips control checks", 2'd0, 0, 0, 1, 1, w, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    req_valid = 0; set_good();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_success_reg();
    t_desc_addr();
    t_desc_meta();
    t_dst_addr();
    t_legal();
    t_dst_meta();
    t_lock();
    t_soft();
    t_control();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule